// File: doc/BRIEF.md
# Memory card clock generator

This block produces the bus clock for a memory card interface from the system clock. It uses a programmable even divider. A power-saving mode stretches each half period by an extra factor. A stall gate parks the card clock in its low phase when the data FIFO cannot keep up. That happens in two cases: a read finds the receive FIFO full, or a write finds the transmit FIFO empty. Together with the card clock, the block drives a one-cycle strobe in the system clock domain on every card clock rising edge. The data path uses this strobe to sample and launch bits synchronously, so it needs no second clock.

Software sets the block up through a small register port. Address 0 holds the mode word: divider, power-save factor, the two stall enables, a byte-granular flag and the block length. Address 1 holds a lock bit. While the lock bit is set, the mode word is frozen. A new divider or power-save setting only takes hold at a card clock falling edge, so each phase of the card clock is always a whole number of half periods.

Top module: `card_clk_gen`

## Requirements
- R1: While reset is asserted and until its synchronous release (two clock edges after the reset input goes high), card_clk, card_ce and ps_err are 0, the mode word is all zero (blk_len reads 0) and the lock bit is clear.
- R2: With power save off, card_clk is high for DIV+1 system cycles and low for DIV+1 system cycles, where DIV is mode bits [7:0].
- R3: When ps_req is 1 and the power-save field (mode bits [10:8], PS) is nonzero, each half period becomes (DIV+1)*(2^PS+1) system cycles.
- R4: When ps_req is 1 and PS is 0, the power-save request has no effect on the card clock, and ps_err is 1 in the following cycle. ps_err is 0 otherwise.
- R5: When read-stall (mode bit 11) is set and xfer_act=1, xfer_rd=1 and fifo_full=1, the card clock is held low at the end of its low phase. It rises on the first edge after the condition clears.
- R6: When write-stall (mode bit 12) is set and xfer_act=1, xfer_rd=0 and fifo_empty=1, the card clock is held low in the same way as for R5.
- R7: A hold never lengthens or shortens a high phase. A clock that is already high falls on schedule.
- R8: A write with wr_addr=0 loads the mode word (bit 13 force-byte, bits [31:14] block length). It is dropped while the lock bit is set. A write with wr_addr=1 always loads the lock bit from wr_data[0].
- R9: blk_len shows the stored block length with bits [1:0] forced to 0 when force-byte is clear, and shows it unchanged when force-byte is set. byte_mode shows force-byte.
- R10: A change to DIV, PS or ps_req only affects the half-period length from the next card_clk falling edge. The count restarts at each toggle.
- R11: card_ce is 1 for exactly the first system cycle in which card_clk is high after being low, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = mode word, 1 = lock bit |
| wr_data | input | 32 | Register write data |
| ps_req | input | 1 | Power-save mode request |
| xfer_act | input | 1 | A data transfer is in progress |
| xfer_rd | input | 1 | Transfer direction: 1 read, 0 write |
| fifo_full | input | 1 | Receive FIFO full |
| fifo_empty | input | 1 | Transmit FIFO empty |
| card_clk | output | 1 | Card bus clock |
| card_ce | output | 1 | One-cycle strobe on each card clock rising edge |
| ps_err | output | 1 | Power save requested with a zero factor |
| blk_len | output | 18 | Effective block length |
| byte_mode | output | 1 | Force-byte flag |

## Verification
The assertions assume that the FIFO flags, ps_req and the transfer direction are synchronous to the system clock and are sampled once per edge. They also assume that the register port is used only after reset has been released. The stimulus changes every input half a cycle away from the sampling edge and writes registers only after the synchronizer has released. The stall patterns raise and drop the FIFO flags in both card clock phases, so holds that start in the high phase are covered as well as those that start at the low-phase boundary.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

  localparam int DATA_W = 32;
  localparam int DIV_W  = 8;
  localparam int PSD_W  = 3;
  localparam int BLK_W  = DATA_W - DIV_W - PSD_W - 3;
  localparam int HALF_W = DIV_W + (1 << PSD_W);

  // Mode word, most significant field first
  typedef struct packed {
    logic [BLK_W-1:0] blk;
    logic             force_byte;
    logic             wr_stall;
    logic             rd_stall;
    logic [PSD_W-1:0] ps_div;
    logic [DIV_W-1:0] div;
  } mode_t;

  function automatic logic [HALF_W-1:0] half_len(input logic [DIV_W-1:0] div,
                                                 input logic [PSD_W-1:0] psd,
                                                 input logic             ps_on);
    logic [HALF_W-1:0] base;
    logic [HALF_W-1:0] mult;
    base = HALF_W'(div) + HALF_W'(1);
    mult = ps_on ? ((HALF_W'(1) << psd) + HALF_W'(1)) : HALF_W'(1);
    return base * mult;
  endfunction

endpackage

// File: rtl/card_clk_cfg.sv
module card_clk_cfg
  import card_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ps_req,
  output mode_t             mode,
  output logic              ps_on,
  output logic              ps_err
);

  mode_t mode_q, mode_d;
  logic  lock_q, lock_d;
  logic  err_q, err_d;
  logic  zero_psd;

  assign zero_psd = (mode_q.ps_div == '0);

  always_comb begin
    mode_d = mode_q;
    lock_d = lock_q;
    if (wr_en) begin
      if (wr_addr)      lock_d = wr_data[0];
      else if (!lock_q) mode_d = mode_t'(wr_data);
    end
    err_d = ps_req && zero_psd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lock_q <= lock_d;
      err_q  <= err_d;
    end
  end

  assign mode   = mode_q;
  assign ps_on  = ps_req && !zero_psd;
  assign ps_err = err_q;

  // R8: a locked mode word ignores writes
  a_r8_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && !wr_addr) |=> $stable(mode_q));

  // R4: zero factor request flags an error next cycle
  a_r4_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_req && mode_q.ps_div == '0) |=> ps_err);

endmodule

// File: rtl/card_clk_stall.sv
module card_clk_stall (
  input  logic xfer_act,
  input  logic xfer_rd,
  input  logic fifo_full,
  input  logic fifo_empty,
  input  logic rd_stall_en,
  input  logic wr_stall_en,
  output logic hold_req
);

  logic rd_block;
  logic wr_block;

  always_comb begin
    rd_block = xfer_rd && rd_stall_en && fifo_full;
    wr_block = !xfer_rd && wr_stall_en && fifo_empty;
    hold_req = xfer_act && (rd_block || wr_block);
  end

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_cfg,
  input  logic             hold_req,
  output logic             card_clk,
  output logic             card_ce
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic             clk_q, clk_d;
  logic             ce_q, ce_d;
  logic             term;

  assign term = (cnt_q == half_q - CNT_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    clk_d  = clk_q;
    ce_d   = 1'b0;
    if (term) begin
      if (!clk_q && hold_req) begin
        cnt_d = cnt_q;
      end else begin
        clk_d = !clk_q;
        cnt_d = '0;
        ce_d  = !clk_q;
        if (clk_q) half_d = half_cfg;
      end
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= CNT_W'(1);
      clk_q  <= 1'b0;
      ce_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
      clk_q  <= clk_d;
      ce_q   <= ce_d;
    end
  end

  assign card_clk = clk_q;
  assign card_ce  = ce_q;

  // R2: the phase counter stays inside the active half period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_q);

  // R7: a high phase always ends on schedule
  a_r7_high_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_q && term) |=> !clk_q);

  // R5 / R6: a low phase is held while a stall is requested
  a_r5_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_q && term && hold_req) |=> !clk_q);

  // R11: the strobe marks only a fresh high phase
  a_r11_ce_rise: assert property (@(posedge clk) disable iff (!rst_n)
    card_ce |-> (card_clk && !$past(card_clk)));

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ps_req,
  input  logic              xfer_act,
  input  logic              xfer_rd,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  output logic              card_clk,
  output logic              card_ce,
  output logic              ps_err,
  output logic [BLK_W-1:0]  blk_len,
  output logic              byte_mode
);

  logic              sync1_q, sync2_q;
  logic              rst_sync_n;
  mode_t             mode;
  logic              ps_on;
  logic              hold_req;
  logic [HALF_W-1:0] half_cfg;

  // Reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign rst_sync_n = sync2_q;

  card_clk_cfg cfg_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ps_req  (ps_req),
    .mode    (mode),
    .ps_on   (ps_on),
    .ps_err  (ps_err)
  );

  card_clk_stall stall_i (
    .xfer_act    (xfer_act),
    .xfer_rd     (xfer_rd),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .rd_stall_en (mode.rd_stall),
    .wr_stall_en (mode.wr_stall),
    .hold_req    (hold_req)
  );

  assign half_cfg = half_len(mode.div, mode.ps_div, ps_on);

  card_clk_div #(.CNT_W(HALF_W)) div_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .half_cfg (half_cfg),
    .hold_req (hold_req),
    .card_clk (card_clk),
    .card_ce  (card_ce)
  );

  assign byte_mode = mode.force_byte;
  assign blk_len   = mode.force_byte ? mode.blk : {mode.blk[BLK_W-1:2], 2'b00};

  // R1: nothing toggles while the synchronized reset is held
  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_sync_n |-> (!card_clk && !card_ce && !ps_err));

endmodule

// File: tb/card_clk_gen_tb.sv
module card_clk_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_addr;
  logic [31:0] wr_data;
  logic        ps_req, xfer_act, xfer_rd, fifo_full, fifo_empty;
  logic        card_clk, card_ce, ps_err, byte_mode;
  logic [17:0] blk_len;

  always #10 clk = ~clk;

  card_clk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ps_req(ps_req), .xfer_act(xfer_act),
    .xfer_rd(xfer_rd), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .card_clk(card_clk), .card_ce(card_ce), .ps_err(ps_err),
    .blk_len(blk_len), .byte_mode(byte_mode)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";

  // Behavioural reference model
  int          m_div, m_psd, m_cnt, m_half;
  bit          m_rs, m_ws, m_fb, m_lock, m_clk, m_ce, m_err, m_s1, m_s2;
  logic [17:0] m_blk;

  task automatic model_reset();
    m_div = 0; m_psd = 0; m_rs = 0; m_ws = 0; m_fb = 0; m_blk = '0;
    m_lock = 0; m_clk = 0; m_ce = 0; m_err = 0; m_cnt = 0; m_half = 1;
  endtask

  initial begin
    model_reset();
    m_s1 = 0; m_s2 = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
      m_s1 = 0; m_s2 = 0;
    end else begin
      if (m_s2) begin
        bit stall;
        bit ps_eff;
        int nhalf;
        stall  = xfer_act && (xfer_rd ? (m_rs && fifo_full) : (m_ws && fifo_empty));
        ps_eff = ps_req && (m_psd != 0);
        nhalf  = (m_div + 1) * (ps_eff ? ((1 << m_psd) + 1) : 1);
        m_ce   = 0;
        if (m_cnt == m_half - 1) begin
          if (!(m_clk == 0 && stall)) begin
            if (m_clk) m_half = nhalf;
            else       m_ce = 1;
            m_clk = !m_clk;
            m_cnt = 0;
          end
        end else begin
          m_cnt++;
        end
        m_err = ps_req && (m_psd == 0);
        if (wr_en) begin
          if (wr_addr) m_lock = wr_data[0];
          else if (!m_lock) begin
            m_div = int'(wr_data[7:0]); m_psd = int'(wr_data[10:8]);
            m_rs = wr_data[11]; m_ws = wr_data[12]; m_fb = wr_data[13];
            m_blk = wr_data[31:14];
          end
        end
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  task automatic chk1(string nm, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk1("card_clk", int'(card_clk), int'(m_clk));
      chk1("card_ce", int'(card_ce), int'(m_ce));
      chk1("ps_err", int'(ps_err), int'(m_err));
      chk1("blk_len", int'(blk_len), int'(m_fb ? m_blk : {m_blk[17:2], 2'b00}));
      chk1("byte_mode", int'(byte_mode), int'(m_fb));
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [31:0] mw(int div, int psd, bit rs, bit ws, bit fb, int blk);
    return {18'(blk), fb, ws, rs, 3'(psd), 8'(div)};
  endfunction

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = '0; ps_req = 0;
    xfer_act = 0; xfer_rd = 0; fifo_full = 0; fifo_empty = 0;
    cur_req = "R1";
    run(4);
    @(negedge clk) rst_n = 1;
    run(6);
    cur_req = "R2"; run(20);
    wr(0, mw(3, 0, 0, 0, 0, 0)); run(60);
    wr(0, mw(0, 0, 0, 0, 0, 0)); run(20);
    cur_req = "R4"; ps_req = 1; run(30); ps_req = 0; run(4);
    cur_req = "R3"; wr(0, mw(1, 2, 0, 0, 0, 0)); ps_req = 1; run(120);
    cur_req = "R10"; wr(0, mw(4, 1, 0, 0, 0, 0)); run(7); ps_req = 0; run(80);
    wr(0, mw(2, 0, 1, 1, 0, 0));
    cur_req = "R5"; xfer_act = 1; xfer_rd = 1;
    fifo_full = 1; run(25); fifo_full = 0; run(20);
    for (int i = 0; i < 90; i++) begin
      @(negedge clk); fifo_full = (i % 7) < 3;
    end
    fifo_full = 0;
    cur_req = "R6"; xfer_rd = 0;
    fifo_empty = 1; run(25); fifo_empty = 0; run(10);
    cur_req = "R7";
    for (int i = 0; i < 90; i++) begin
      @(negedge clk); fifo_empty = (i % 5) == 1;
    end
    fifo_empty = 1; xfer_act = 0; run(20);
    cur_req = "R5"; xfer_act = 1; wr(0, mw(2, 0, 0, 0, 0, 0)); run(30);
    fifo_empty = 0; xfer_act = 0;
    cur_req = "R9";
    wr(0, mw(0, 0, 0, 0, 0, 'h207)); run(3);
    wr(0, mw(0, 0, 0, 0, 1, 'h207)); run(3);
    cur_req = "R8";
    wr(1, 32'h1); wr(0, mw(5, 0, 0, 0, 0, 'h3f)); run(20);
    wr(1, 32'h0); wr(0, mw(5, 0, 0, 0, 1, 'h3f)); run(40);
    cur_req = "R11"; wr(0, mw(1, 0, 0, 0, 0, 0)); run(30);
    cur_req = "R1"; @(negedge clk) rst_n = 0; run(3);
    @(negedge clk) rst_n = 1; run(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule